// File: doc/BRIEF.md
# Two-Stage Filtered Warp Issue Scheduler

This block picks at most one warp instruction per cycle from a table of sixteen resident warp entries, in two steps. The first step is a one-bit-per-entry array holding the dependency-ready state of each warp. It produces a registered candidate vector. In the following cycle only the candidate entries are read from the wide detail array, which holds warp ID, opcode and active mask. The second step then applies the functional-unit availability check and a greedy-then-oldest choice. The chosen instruction is registered onto the issue port, with a one-hot unit-class flag derived from its opcode.

A warp is placed with an allocate strobe that writes its detail entry, and it is removed with a release strobe. The external scoreboard sets and clears the ready bits. Per-class busy inputs report which execution units cannot accept work. A running count of detail-array entry reads shows how well the first step filters accesses: when no warp is ready, the detail array is not read at all.

Top module: `warp_sched_2s`

## Requirements
- R1: After reset no entry is allocated or ready, `issue_valid_o` is 0 and `read_count_o` is 0.
- R2: The first step looks only at the ready bit. A ready bit set by `ready_set_i` at edge E is captured as a candidate at E+1, and the warp appears on the issue port after edge E+2 when its unit is free. An entry that is not a candidate never issues.
- R3: Unit availability is checked only in the second step, against `unit_busy_i` at the edge that registers the issue (bit0 ALU, bit1 load/store, bit2 SFU). A blocked candidate stays ready and issues on the first such edge where its unit is free.
- R4: At each edge, `read_count_o` grows by the number of entries that are candidates and still allocated and ready. When the candidate vector is empty it does not change.
- R5: The ready bit of a warp is cleared at the edge that issues it. A candidate captured before that clear is dropped, so the same warp is never issued on two consecutive cycles without a new ready set.
- R6: Greedy: if the last issued warp is eligible again, it is chosen over any older eligible warp.
- R7: Otherwise the oldest eligible warp in allocation order is chosen. Each entry's age starts at 0 on allocation and is incremented when any other entry is allocated, saturating at 255. Ties go to the lowest index.
- R8: `issue_unit_o` is one-hot and is set from opcode bits [5:4]: 01 gives load/store (bit1), 10 gives SFU (bit2), 00 and 11 give ALU (bit0).
- R9: At most one warp issues per cycle. The issued index, warp ID, opcode and mask equal the values written at allocation.
- R10: `ready_set_i` on an unallocated or released entry is ignored. Such an entry never issues and causes no reads.
- R11: When the same entry gets `ready_set_i` and `ready_clr_i` in one cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate strobe |
| alloc_idx_i | input | 4 | Entry to allocate |
| alloc_wid_i | input | 5 | Warp ID to store |
| alloc_op_i | input | 6 | Opcode to store |
| alloc_mask_i | input | 32 | Thread active mask to store |
| release_valid_i | input | 1 | Release strobe |
| release_idx_i | input | 4 | Entry to release |
| ready_set_i | input | 16 | Per-entry ready set from the scoreboard |
| ready_clr_i | input | 16 | Per-entry ready clear from the scoreboard |
| unit_busy_i | input | 3 | Busy per unit class (ALU, load/store, SFU) |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_idx_o | output | 4 | Entry index of the issued warp |
| issue_wid_o | output | 5 | Warp ID of the issued warp |
| issue_op_o | output | 6 | Opcode of the issued warp |
| issue_mask_o | output | 32 | Active mask of the issued warp |
| issue_unit_o | output | 3 | One-hot target unit class |
| read_count_o | output | 32 | Detail-array entry reads so far |

## Verification
The timing is fixed. A ready set sampled at edge E becomes a candidate at E+1 and is seen on the issue port just after E+2. The read count for a candidate is updated at that same E+2 edge. A busy input acts at the edge that registers the issue. The bench drives inputs on falling edges and keeps a behavioural model that steps on each rising edge. On every falling edge it compares the model with the issue port and the read count, so each result is checked in the cycle it is due. The directed checks count three falling edges from the start of a pulse to reach the E+2 result, and four for the follow-on cycle where a stale candidate has to be dropped.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int unsigned N_UNIT = 3;

  // opcode class field -> one-hot unit: bit0 alu, bit1 ldst, bit2 sfu
  function automatic logic [N_UNIT-1:0] unit_onehot(input logic [1:0] op_hi);
    logic [N_UNIT-1:0] u;
    case (op_hi)
      2'b01:   u = 3'b010;
      2'b10:   u = 3'b100;
      default: u = 3'b001;
    endcase
    return u;
  endfunction
endpackage

// File: rtl/ws_ready_filter.sv
module ws_ready_filter #(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alloc_en_i,
  input  logic [IDX_W-1:0]     alloc_idx_i,
  input  logic                 rel_en_i,
  input  logic [IDX_W-1:0]     rel_idx_i,
  input  logic [N_ENTRIES-1:0] set_i,
  input  logic [N_ENTRIES-1:0] clr_i,
  input  logic                 iss_en_i,
  input  logic [IDX_W-1:0]     iss_idx_i,
  output logic [N_ENTRIES-1:0] vld_o,
  output logic [N_ENTRIES-1:0] rdy_o,
  output logic [N_ENTRIES-1:0] cand_o
);
  logic [N_ENTRIES-1:0] vld_q, rdy_q, cand_q;
  logic [N_ENTRIES-1:0] vld_d, rdy_d;

  always_comb begin
    vld_d = vld_q;
    rdy_d = rdy_q;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (alloc_en_i && alloc_idx_i == IDX_W'(i)) begin
        vld_d[i] = 1'b1;
        rdy_d[i] = 1'b0;
      end else if (rel_en_i && rel_idx_i == IDX_W'(i)) begin
        vld_d[i] = 1'b0;
        rdy_d[i] = 1'b0;
      end else if ((iss_en_i && iss_idx_i == IDX_W'(i)) || clr_i[i]) begin
        rdy_d[i] = 1'b0;
      end else if (set_i[i] && vld_q[i]) begin
        rdy_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      rdy_q  <= '0;
      cand_q <= '0;
    end else begin
      cand_q <= vld_q & rdy_q;
      vld_q  <= vld_d;
      rdy_q  <= rdy_d;
    end
  end

  assign vld_o  = vld_q;
  assign rdy_o  = rdy_q;
  assign cand_o = cand_q;

  // R5: issuing a warp drops its ready bit at that same edge
  p_clear_on_issue_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_en_i |=> rdy_q[$past(iss_idx_i)] == 1'b0);

  // R11: clear beats a simultaneous set
  p_clear_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((rdy_q & $past(clr_i)) == '0));
endmodule

// File: rtl/ws_entry_table.sv
module ws_entry_table #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned WID_W     = 5,
  parameter int unsigned OP_W      = 6,
  parameter int unsigned MASK_W    = 32,
  parameter int unsigned AGE_W     = 8,
  parameter int unsigned CNT_W     = 32,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alloc_en_i,
  input  logic [IDX_W-1:0]     alloc_idx_i,
  input  logic [WID_W-1:0]     alloc_wid_i,
  input  logic [OP_W-1:0]      alloc_op_i,
  input  logic [MASK_W-1:0]    alloc_mask_i,
  input  logic [N_ENTRIES-1:0] vld_i,
  input  logic [N_ENTRIES-1:0] rd_en_i,
  output logic [WID_W-1:0]     rd_wid_o  [N_ENTRIES],
  output logic [OP_W-1:0]      rd_op_o   [N_ENTRIES],
  output logic [MASK_W-1:0]    rd_amask_o[N_ENTRIES],
  output logic [AGE_W-1:0]     age_o     [N_ENTRIES],
  output logic [CNT_W-1:0]     rd_cnt_o
);
  logic [WID_W-1:0]  wid_q  [N_ENTRIES];
  logic [OP_W-1:0]   op_q   [N_ENTRIES];
  logic [MASK_W-1:0] amask_q[N_ENTRIES];
  logic [AGE_W-1:0]  age_q  [N_ENTRIES];
  logic [CNT_W-1:0]  rd_cnt_q;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic hit;
    assign hit = alloc_en_i && alloc_idx_i == IDX_W'(g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wid_q[g]   <= '0;
        op_q[g]    <= '0;
        amask_q[g] <= '0;
        age_q[g]   <= '0;
      end else if (hit) begin
        wid_q[g]   <= alloc_wid_i;
        op_q[g]    <= alloc_op_i;
        amask_q[g] <= alloc_mask_i;
        age_q[g]   <= '0;
      end else if (alloc_en_i && vld_i[g] && age_q[g] != AGE_MAX) begin
        age_q[g]   <= age_q[g] + 1'b1;
      end
    end

    // read port gated: unready entries are not accessed
    assign rd_wid_o[g]   = rd_en_i[g] ? wid_q[g]   : '0;
    assign rd_op_o[g]    = rd_en_i[g] ? op_q[g]    : '0;
    assign rd_amask_o[g] = rd_en_i[g] ? amask_q[g] : '0;
    assign age_o[g]      = age_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_cnt_q <= '0;
    else         rd_cnt_q <= rd_cnt_q + CNT_W'($countones(rd_en_i));
  end

  assign rd_cnt_o = rd_cnt_q;

  // R7: a freshly allocated entry is the youngest
  p_alloc_young_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |=> age_q[$past(alloc_idx_i)] == '0);
endmodule

// File: rtl/ws_gto_pick.sv
module ws_gto_pick #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned AGE_W     = 8,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] elig_i,
  input  logic [AGE_W-1:0]     age_i[N_ENTRIES],
  input  logic                 last_v_i,
  input  logic [IDX_W-1:0]     last_idx_i,
  output logic                 pick_v_o,
  output logic [IDX_W-1:0]     pick_idx_o
);
  logic             found;
  logic [IDX_W-1:0] best;
  logic [AGE_W-1:0] best_age;

  // oldest eligible, lowest index on a tie
  always_comb begin
    found    = 1'b0;
    best     = '0;
    best_age = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (elig_i[i] && (!found || age_i[i] > best_age)) begin
        found    = 1'b1;
        best     = IDX_W'(i);
        best_age = age_i[i];
      end
    end
  end

  assign pick_v_o   = found;
  assign pick_idx_o = (last_v_i && elig_i[last_idx_i]) ? last_idx_i : best;
endmodule

// File: rtl/warp_sched_2s.sv
module warp_sched_2s #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned WID_W     = 5,
  parameter int unsigned OP_W      = 6,
  parameter int unsigned MASK_W    = 32,
  parameter int unsigned AGE_W     = 8,
  parameter int unsigned CNT_W     = 32,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
  localparam int unsigned N_UNIT   = ws_pkg::N_UNIT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alloc_valid_i,
  input  logic [IDX_W-1:0]     alloc_idx_i,
  input  logic [WID_W-1:0]     alloc_wid_i,
  input  logic [OP_W-1:0]      alloc_op_i,
  input  logic [MASK_W-1:0]    alloc_mask_i,
  input  logic                 release_valid_i,
  input  logic [IDX_W-1:0]     release_idx_i,
  input  logic [N_ENTRIES-1:0] ready_set_i,
  input  logic [N_ENTRIES-1:0] ready_clr_i,
  input  logic [N_UNIT-1:0]    unit_busy_i,
  output logic                 issue_valid_o,
  output logic [IDX_W-1:0]     issue_idx_o,
  output logic [WID_W-1:0]     issue_wid_o,
  output logic [OP_W-1:0]      issue_op_o,
  output logic [MASK_W-1:0]    issue_mask_o,
  output logic [N_UNIT-1:0]    issue_unit_o,
  output logic [CNT_W-1:0]     read_count_o
);
  logic [N_ENTRIES-1:0] vld_w, rdy_w, cand_w, rd_en_w, elig_w;
  logic [WID_W-1:0]     rd_wid  [N_ENTRIES];
  logic [OP_W-1:0]      rd_op   [N_ENTRIES];
  logic [MASK_W-1:0]    rd_amask[N_ENTRIES];
  logic [AGE_W-1:0]     age_w   [N_ENTRIES];
  logic [N_UNIT-1:0]    unit_w  [N_ENTRIES];
  logic                 pick_v;
  logic [IDX_W-1:0]     pick_idx;
  logic                 last_v_q, last_v_d;
  logic [IDX_W-1:0]     last_idx_q, last_idx_d;

  ws_ready_filter #(.N_ENTRIES(N_ENTRIES)) i_filter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_en_i  (alloc_valid_i),
    .alloc_idx_i (alloc_idx_i),
    .rel_en_i    (release_valid_i),
    .rel_idx_i   (release_idx_i),
    .set_i       (ready_set_i),
    .clr_i       (ready_clr_i),
    .iss_en_i    (pick_v),
    .iss_idx_i   (pick_idx),
    .vld_o       (vld_w),
    .rdy_o       (rdy_w),
    .cand_o      (cand_w)
  );

  // stale candidates (ready dropped since capture) are not read
  assign rd_en_w = cand_w & rdy_w & vld_w;

  ws_entry_table #(
    .N_ENTRIES (N_ENTRIES),
    .WID_W     (WID_W),
    .OP_W      (OP_W),
    .MASK_W    (MASK_W),
    .AGE_W     (AGE_W),
    .CNT_W     (CNT_W)
  ) i_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_en_i   (alloc_valid_i),
    .alloc_idx_i  (alloc_idx_i),
    .alloc_wid_i  (alloc_wid_i),
    .alloc_op_i   (alloc_op_i),
    .alloc_mask_i (alloc_mask_i),
    .vld_i        (vld_w),
    .rd_en_i      (rd_en_w),
    .rd_wid_o     (rd_wid),
    .rd_op_o      (rd_op),
    .rd_amask_o   (rd_amask),
    .age_o        (age_w),
    .rd_cnt_o     (read_count_o)
  );

  // unit check happens only on the entries read in this stage
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_elig
    assign unit_w[g] = ws_pkg::unit_onehot(rd_op[g][OP_W-1 -: 2]);
    assign elig_w[g] = rd_en_w[g] && ((unit_w[g] & unit_busy_i) == '0);
  end

  ws_gto_pick #(.N_ENTRIES(N_ENTRIES), .AGE_W(AGE_W)) i_pick (
    .elig_i     (elig_w),
    .age_i      (age_w),
    .last_v_i   (last_v_q),
    .last_idx_i (last_idx_q),
    .pick_v_o   (pick_v),
    .pick_idx_o (pick_idx)
  );

  assign last_idx_d = pick_v ? pick_idx : last_idx_q;
  assign last_v_d   = (pick_v || last_v_q) &&
                      !(release_valid_i && release_idx_i == last_idx_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_valid_o <= 1'b0;
      issue_idx_o   <= '0;
      issue_wid_o   <= '0;
      issue_op_o    <= '0;
      issue_mask_o  <= '0;
      issue_unit_o  <= '0;
      last_v_q      <= 1'b0;
      last_idx_q    <= '0;
    end else begin
      issue_valid_o <= pick_v;
      issue_idx_o   <= pick_v ? pick_idx : '0;
      issue_wid_o   <= pick_v ? rd_wid[pick_idx] : '0;
      issue_op_o    <= pick_v ? rd_op[pick_idx] : '0;
      issue_mask_o  <= pick_v ? rd_amask[pick_idx] : '0;
      issue_unit_o  <= pick_v ? unit_w[pick_idx] : '0;
      last_v_q      <= last_v_d;
      last_idx_q    <= last_idx_d;
    end
  end

  // R8: exactly one unit class per issued instruction
  p_unit_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> $countones(issue_unit_o) == 1);

  // R3: never issued into a unit busy at the issuing edge
  p_busy_respected_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (($past(unit_busy_i) & issue_unit_o) == '0));

  // R2: issued warp was a candidate of the first stage
  p_from_candidate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (($past(cand_w) >> issue_idx_o) & N_ENTRIES'(1)) != '0);

  // R2: empty candidate vector gives no issue
  p_idle_no_issue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_w == '0) |=> !issue_valid_o);

  // R4: empty candidate vector reads nothing
  p_idle_no_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_w == '0) |=> $stable(read_count_o));

  // R5: no back-to-back issue of the same entry
  p_no_repeat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |=> !(issue_valid_o && issue_idx_o == $past(issue_idx_o)));
endmodule

// File: tb/test_warp_sched_2s.sv
module test_warp_sched_2s;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        d_alloc = 1'b0;
  logic [3:0]  d_aidx = '0;
  logic [4:0]  d_wid = '0;
  logic [5:0]  d_op = '0;
  logic [31:0] d_mask = '0;
  logic        d_rel = 1'b0;
  logic [3:0]  d_ridx = '0;
  logic [15:0] d_set = '0;
  logic [15:0] d_clr = '0;
  logic [2:0]  d_busy = '0;

  logic        issue_valid;
  logic [3:0]  issue_idx;
  logic [4:0]  issue_wid;
  logic [5:0]  issue_op;
  logic [31:0] issue_mask;
  logic [2:0]  issue_unit;
  logic [31:0] read_count;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  warp_sched_2s i_warp_sched_2s (
    .clk_i (clk), .rst_ni (rst_n),
    .alloc_valid_i (d_alloc), .alloc_idx_i (d_aidx), .alloc_wid_i (d_wid),
    .alloc_op_i (d_op), .alloc_mask_i (d_mask),
    .release_valid_i (d_rel), .release_idx_i (d_ridx),
    .ready_set_i (d_set), .ready_clr_i (d_clr), .unit_busy_i (d_busy),
    .issue_valid_o (issue_valid), .issue_idx_o (issue_idx), .issue_wid_o (issue_wid),
    .issue_op_o (issue_op), .issue_mask_o (issue_mask), .issue_unit_o (issue_unit),
    .read_count_o (read_count)
  );

  // ---------------- behavioural reference ----------------
  logic [15:0] m_vld = '0, m_rdy = '0, m_cand = '0;
  int          m_age[N];
  logic [4:0]  m_wid[N];
  logic [5:0]  m_op[N];
  logic [31:0] m_mask[N];
  int          m_last = 0;
  bit          m_last_v = 0;
  bit          m_iv = 0;
  int          m_iidx = 0;
  logic [4:0]  m_iwid = '0;
  logic [5:0]  m_iop = '0;
  logic [31:0] m_imask = '0;
  logic [2:0]  m_iunit = '0;
  longint      m_cnt = 0;

  function automatic logic [2:0] unit_of(input logic [5:0] op);
    if (op[5:4] == 2'b01) return 3'b010;
    if (op[5:4] == 2'b10) return 3'b100;
    return 3'b001;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vld = '0; m_rdy = '0; m_cand = '0; m_last = 0; m_last_v = 0;
      m_iv = 0; m_iidx = 0; m_iwid = '0; m_iop = '0; m_imask = '0; m_iunit = '0;
      m_cnt = 0;
      for (int i = 0; i < N; i++) begin
        m_age[i] = 0; m_wid[i] = '0; m_op[i] = '0; m_mask[i] = '0;
      end
    end else begin
      automatic logic [15:0] pv = m_vld;
      automatic logic [15:0] pr = m_rdy;
      automatic logic [15:0] pc = m_cand;
      automatic logic [15:0] el = '0;
      automatic int best = -1;
      automatic int reads = 0;
      for (int i = 0; i < N; i++) begin
        if (pc[i] && pr[i] && pv[i]) begin
          reads++;
          if ((unit_of(m_op[i]) & d_busy) == 3'b000) el[i] = 1'b1;
        end
      end
      if (m_last_v && el[m_last]) best = m_last;
      else
        for (int i = 0; i < N; i++)
          if (el[i] && (best < 0 || m_age[i] > m_age[best])) best = i;
      m_cnt += reads;
      if (best >= 0) begin
        m_iv = 1; m_iidx = best; m_iwid = m_wid[best]; m_iop = m_op[best];
        m_imask = m_mask[best]; m_iunit = unit_of(m_op[best]);
        m_last = best; m_last_v = 1;
      end else begin
        m_iv = 0; m_iidx = 0; m_iwid = '0; m_iop = '0; m_imask = '0; m_iunit = '0;
      end
      if (d_rel && int'(d_ridx) == m_last) m_last_v = 0;
      m_cand = pv & pr;
      for (int i = 0; i < N; i++) begin
        if (d_alloc && int'(d_aidx) == i) begin
          m_vld[i] = 1; m_rdy[i] = 0;
        end else if (d_rel && int'(d_ridx) == i) begin
          m_vld[i] = 0; m_rdy[i] = 0;
        end else if (best == i || d_clr[i]) m_rdy[i] = 0;
        else if (d_set[i] && pv[i]) m_rdy[i] = 1;
      end
      if (d_alloc) begin
        for (int i = 0; i < N; i++)
          if (i != int'(d_aidx) && pv[i] && m_age[i] < 255) m_age[i]++;
        m_age[d_aidx] = 0; m_wid[d_aidx] = d_wid; m_op[d_aidx] = d_op;
        m_mask[d_aidx] = d_mask;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R9: full port comparison against the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 model valid", 64'(issue_valid), 64'(m_iv));
      if (m_iv) begin
        check("R9 model idx", 64'(issue_idx), 64'(m_iidx));
        check("R9 model wid", 64'(issue_wid), 64'(m_iwid));
        check("R9 model op", 64'(issue_op), 64'(m_iop));
        check("R9 model mask", 64'(issue_mask), 64'(m_imask));
        check("R8 model unit", 64'(issue_unit), 64'(m_iunit));
      end
      check("R4 model count", 64'(read_count), 64'(m_cnt));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_alloc(input int idx, input logic [4:0] wid, input logic [5:0] op,
                          input logic [31:0] mask);
    d_alloc = 1; d_aidx = 4'(idx); d_wid = wid; d_op = op; d_mask = mask;
    tick(1);
    d_alloc = 0;
  endtask

  task automatic pulse_rdy(input logic [15:0] s, input logic [15:0] c);
    d_set = s; d_clr = c;
    tick(1);
    d_set = '0; d_clr = '0;
  endtask

  task automatic expect_issue(input string tag, input bit v, input int idx);
    check({tag, " valid"}, 64'(issue_valid), 64'(v));
    if (v) check({tag, " idx"}, 64'(issue_idx), 64'(idx));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] c0;
    for (int i = 0; i < N; i++) begin
      m_age[i] = 0; m_wid[i] = '0; m_op[i] = '0; m_mask[i] = '0;
    end
    tick(3);
    rst_n = 1;
    tick(1);
    // R1
    check("R1 issue_valid", 64'(issue_valid), 64'd0);
    check("R1 read_count", 64'(read_count), 64'd0);

    do_alloc(0, 5'h03, 6'h01, 32'h0000_00ff);
    do_alloc(1, 5'h07, 6'h10, 32'hffff_0000);
    do_alloc(2, 5'h0b, 6'h20, 32'h1234_5678);
    do_alloc(3, 5'h11, 6'h31, 32'hdead_beef);
    // R10: ready on an unallocated entry
    pulse_rdy(16'h0020, 16'h0);
    tick(3);
    expect_issue("R10 unallocated", 0, 0);
    check("R10 no reads", 64'(read_count), 64'd0);

    // R2/R8: single ready warp, two-cycle path
    pulse_rdy(16'h0004, 16'h0);
    expect_issue("R2 after E", 0, 0);
    tick(1);
    expect_issue("R2 after E+1", 0, 0);
    tick(1);
    expect_issue("R2 after E+2", 1, 2);
    check("R8 sfu unit", 64'(issue_unit), 64'h4);
    check("R9 wid", 64'(issue_wid), 64'h0b);
    check("R4 one read", 64'(read_count), 64'd1);
    tick(1);
    expect_issue("R5 stale dropped", 0, 0);
    check("R5 no stale read", 64'(read_count), 64'd1);

    // R7: oldest first
    pulse_rdy(16'h000a, 16'h0);
    tick(2);
    expect_issue("R7 oldest", 1, 1);
    check("R8 ldst unit", 64'(issue_unit), 64'h2);
    tick(1);
    expect_issue("R7 next", 1, 3);
    check("R4 three reads", 64'(read_count), 64'd4);

    // R6: greedy keeps last issued warp
    pulse_rdy(16'h0009, 16'h0);
    tick(2);
    expect_issue("R6 greedy", 1, 3);
    check("R8 alu unit", 64'(issue_unit), 64'h1);
    tick(1);
    expect_issue("R6 then oldest", 1, 0);
    check("R4 count", 64'(read_count), 64'd7);

    // R3: unit busy blocks in stage two, issue once free
    d_busy = 3'b001;
    pulse_rdy(16'h0001, 16'h0);
    tick(2);
    expect_issue("R3 blocked", 0, 0);
    d_busy = 3'b000;
    tick(1);
    expect_issue("R3 freed", 1, 0);

    // R11: clear beats set
    pulse_rdy(16'h0002, 16'h0002);
    tick(2);
    expect_issue("R11 same cycle", 0, 0);
    tick(1);
    expect_issue("R11 same cycle+1", 0, 0);
    pulse_rdy(16'h0002, 16'h0);
    pulse_rdy(16'h0, 16'h0002);
    tick(1);
    expect_issue("R11 late clear", 0, 0);
    tick(1);
    expect_issue("R11 late clear+1", 0, 0);

    // R10: released entry ignores ready
    d_rel = 1; d_ridx = 4'd3;
    tick(1);
    d_rel = 0;
    c0 = read_count;
    pulse_rdy(16'h0008, 16'h0);
    tick(2);
    expect_issue("R10 released", 0, 0);
    tick(1);
    check("R10 released no read", 64'(read_count), 64'(c0));

    // R9: reallocated entry carries new fields
    do_alloc(3, 5'h1d, 6'h12, 32'hf0f0_1234);
    pulse_rdy(16'h0008, 16'h0);
    tick(2);
    expect_issue("R9 realloc", 1, 3);
    check("R9 realloc wid", 64'(issue_wid), 64'h1d);
    check("R9 realloc mask", 64'(issue_mask), 64'hf0f0_1234);
    check("R8 realloc unit", 64'(issue_unit), 64'h2);

    // random traffic, compared against the model every cycle
    for (int k = 0; k < 4000; k++) begin
      automatic int a = -1;
      automatic int st = $urandom_range(0, 15);
      d_alloc = 0; d_rel = 0;
      if ($urandom_range(0, 9) < 3)
        for (int j = 0; j < N; j++)
          if (a < 0 && !m_vld[(st + j) % N]) a = (st + j) % N;
      if (a >= 0) begin
        d_alloc = 1; d_aidx = 4'(a); d_wid = 5'($urandom); d_op = 6'($urandom);
        d_mask = $urandom;
      end
      if ($urandom_range(0, 9) < 1) begin
        automatic int r = $urandom_range(0, 15);
        if (m_vld[r] && r != a) begin
          d_rel = 1; d_ridx = 4'(r);
        end
      end
      d_set  = 16'($urandom) & 16'($urandom);
      d_clr  = 16'($urandom) & 16'($urandom) & 16'($urandom);
      d_busy = 3'($urandom) & 3'($urandom);
      tick(1);
    end
    d_alloc = 0; d_rel = 0; d_set = '0; d_clr = '0; d_busy = '0;
    tick(3);

    done = 1;
    summary();
    $finish;
  end
endmodule